// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic/logic unit of a 32-bit integer core. Each cycle it takes a 4-bit operation code, a first operand, and a second operand. The second operand comes either from a register value shifted left by a constant amount, or from an 8-bit constant rotated right by an even distance. The block returns a 32-bit result, a write strobe for that result and the candidate N, Z, C, V flags. It also holds the architectural flag store. The stored carry feeds the carry-using operations, and the shifter carry feeds the logical ones.

The flag store loads only when an operation is presented and either flag setting is requested or the operation is one of the four compare-only codes. This lets a carry produced by a low-word add be consumed by a following add-with-carry, so 64-bit arithmetic is built from two 32-bit operations.

Top module: `dp_alu`

## Requirements
- R1: Codes 0x4 (add), 0x2 (subtract, A−B) and 0x3 (reverse subtract, B−A) produce the 32-bit wrapped result.
- R2: Codes 0x5 (A+B+C), 0x6 (A−B+C−1) and 0x7 (B−A+C−1) use the stored carry flag C. An add setting flags followed by code 0x5 forms a 64-bit sum.
- R3: Codes 0x0 (AND), 0x1 (XOR), 0xC (OR) and 0xE (A AND NOT B) act bitwise over all 32 bits.
- R4: Code 0xD outputs B and code 0xF outputs NOT B. Operand A has no effect on either.
- R5: Codes 0x8 (test, A AND B), 0x9 (A XOR B), 0xA (A−B) and 0xB (A+B) never assert resultWe and always load all four flags.
- R6: Every other code asserts resultWe, and loads the flags only when setFlags is high.
- R7: N equals result bit 31, and Z is 1 exactly when all 32 result bits are zero.
- R8: For add-type codes, C is the carry out of bit 31. For subtract-type codes, C is 1 when no borrow occurs. For both, V flags signed overflow.
- R9: For logical, move and test codes, C takes the operand-2 shifter carry and V keeps its stored value.
- R10: When useImm is high, operand 2 is immByte rotated right by 2×immRot. Its carry is bit 31 of the rotated value, or the stored C when immRot is 0.
- R11: When useImm is low, operand 2 is regB shifted left by shiftAmt. Its carry is the last bit shifted out, or the stored C when shiftAmt is 0.
- R12: Reset clears all four stored flags.
- R13: With opValid low, resultWe stays low and the stored flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| setFlags | input | 1 | Request flag update for non-compare codes |
| useImm | input | 1 | Select rotated immediate as operand 2 |
| opA | input | 32 | First operand |
| regB | input | 32 | Register source for operand 2 |
| shiftAmt | input | 5 | Left shift applied to regB |
| immByte | input | 8 | Immediate constant |
| immRot | input | 4 | Immediate rotate, in units of two bits |
| result | output | 32 | Operation result |
| resultWe | output | 1 | Result write strobe |
| nextN | output | 1 | Candidate negative flag |
| nextZ | output | 1 | Candidate zero flag |
| nextC | output | 1 | Candidate carry flag |
| nextV | output | 1 | Candidate overflow flag |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry flag |
| flagV | output | 1 | Stored overflow flag |

## Verification
Before each vector the flag store is preloaded with one of three states: carry clear, carry set, or carry and overflow both set. This separates a correct carry-in from a constant one, and a held V from a cleared one. Operands are chosen at the wrap and sign boundaries (all ones plus one, most-negative minus one, equal compares), so carry, no-borrow and overflow are each shown both set and clear. Both operand-2 paths are exercised with a zero and a non-zero rotate or shift, which tells the shifter carry apart from the stored carry. A 64-bit add across two operations, an idle cycle carrying a compare code, and two moves with different A values cover the chaining, quiet and ignored-operand cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_XOR  = 3'd1,
    LG_OR   = 3'd2,
    LG_BIC  = 3'd3,
    LG_PASS = 3'd4,
    LG_INV  = 3'd5
  } logicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      useAdder;  // result and C/V come from the adder
    logic      swapAB;    // reverse operand order into the adder
    logic      invY;      // invert the second adder input
    cinSel_e   cinSel;    // adder carry-in source
    logicSel_e logicSel;  // bitwise function
    logic      writeRes;  // result write strobe
    logic      flagEn;    // flag store load enable
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opcode,
  input  logic       setFlags,
  output aluStrobe_t strb
);

  logic isCompare;

  // Codes 0x8..0xB are the compare-only group
  assign isCompare = (opcode[3:2] == 2'b10);

  always_comb begin
    strb          = '0;
    strb.cinSel   = CIN_ZERO;
    strb.logicSel = LG_AND;
    unique case (aluOp_e'(opcode))
      OP_AND: strb.logicSel = LG_AND;
      OP_EOR: strb.logicSel = LG_XOR;
      OP_TST: strb.logicSel = LG_AND;
      OP_TEQ: strb.logicSel = LG_XOR;
      OP_ORR: strb.logicSel = LG_OR;
      OP_MOV: strb.logicSel = LG_PASS;
      OP_BIC: strb.logicSel = LG_BIC;
      OP_MVN: strb.logicSel = LG_INV;
      OP_ADD, OP_CMN: begin
        strb.useAdder = 1'b1;
      end
      OP_ADC: begin
        strb.useAdder = 1'b1;
        strb.cinSel   = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        strb.useAdder = 1'b1;
        strb.invY     = 1'b1;
        strb.cinSel   = CIN_ONE;
      end
      OP_SBC: begin
        strb.useAdder = 1'b1;
        strb.invY     = 1'b1;
        strb.cinSel   = CIN_FLAG;
      end
      OP_RSB: begin
        strb.useAdder = 1'b1;
        strb.swapAB   = 1'b1;
        strb.invY     = 1'b1;
        strb.cinSel   = CIN_ONE;
      end
      OP_RSC: begin
        strb.useAdder = 1'b1;
        strb.swapAB   = 1'b1;
        strb.invY     = 1'b1;
        strb.cinSel   = CIN_FLAG;
      end
      default: strb.logicSel = LG_AND;
    endcase
    strb.writeRes = opValid && !isCompare;
    strb.flagEn   = opValid && (setFlags || isCompare);
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8,
  parameter int RotW  = 4,
  localparam int ShW  = $clog2(DataW),
  localparam int Msb  = DataW - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobe_t       strb,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] regB,
  input  logic [ShW-1:0]   shiftAmt,
  input  logic             useImm,
  input  logic [ImmW-1:0]  immByte,
  input  logic [RotW-1:0]  immRot,
  output logic [DataW-1:0] result,
  output logic             resultWe,
  output logic             nextN,
  output logic             nextZ,
  output logic             nextC,
  output logic             nextV,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  // ---------------- operand 2 ----------------
  logic [DataW-1:0]   immExt;
  logic [2*DataW-1:0] immDbl;
  logic [DataW-1:0]   immVal;
  logic [DataW:0]     shExt;
  logic [DataW-1:0]   opB;
  logic               shCarry;

  assign immExt = {{(DataW-ImmW){1'b0}}, immByte};
  assign immDbl = {immExt, immExt} >> {immRot, 1'b0};
  assign immVal = immDbl[DataW-1:0];
  assign shExt  = {1'b0, regB} << shiftAmt;

  always_comb begin
    if (useImm) begin
      opB     = immVal;
      shCarry = (immRot == '0) ? flagC : immVal[Msb];
    end else begin
      opB     = shExt[DataW-1:0];
      shCarry = (shiftAmt == '0) ? flagC : shExt[DataW];
    end
  end

  // ---------------- adder ----------------
  logic [DataW-1:0] addX, addY;
  logic             addCin;
  logic [DataW:0]   addSum;
  logic             addOvf;

  always_comb begin
    addX = strb.swapAB ? opB : opA;
    addY = strb.swapAB ? opA : opB;
    if (strb.invY) addY = ~addY;
    unique case (strb.cinSel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = flagC;
      default:  addCin = 1'b0;
    endcase
  end

  assign addSum = {1'b0, addX} + {1'b0, addY} + {{DataW{1'b0}}, addCin};
  assign addOvf = (addX[Msb] == addY[Msb]) && (addSum[Msb] != addX[Msb]);

  // ---------------- bitwise unit ----------------
  logic [DataW-1:0] logicRes;

  always_comb begin
    unique case (strb.logicSel)
      LG_XOR:  logicRes = opA ^ opB;
      LG_OR:   logicRes = opA | opB;
      LG_BIC:  logicRes = opA & ~opB;
      LG_PASS: logicRes = opB;
      LG_INV:  logicRes = ~opB;
      default: logicRes = opA & opB;
    endcase
  end

  // ---------------- result and flags ----------------
  assign result   = strb.useAdder ? addSum[DataW-1:0] : logicRes;
  assign resultWe = strb.writeRes;
  assign nextN    = result[Msb];
  assign nextZ    = (result == '0);
  assign nextC    = strb.useAdder ? addSum[DataW] : shCarry;
  assign nextV    = strb.useAdder ? addOvf : flagV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagC <= 1'b0;
      flagV <= 1'b0;
    end else if (strb.flagEn) begin
      flagN <= nextN;
      flagZ <= nextZ;
      flagC <= nextC;
      flagV <= nextV;
    end
  end

  // ---------------- assertions ----------------
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flagEn |=> $stable({flagN, flagZ, flagC, flagV}));

  a_r9_logic_keeps_v: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagEn && !strb.useAdder) |=> (flagV == $past(flagV)));

  a_r7_z_tracks_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagEn |=> (flagZ == ($past(result) == '0)));

  a_r7_n_tracks_msb: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagEn |=> (flagN == $past(result[Msb])));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import alu_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8,
  parameter int RotW  = 4,
  localparam int ShW  = $clog2(DataW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opcode,
  input  logic             setFlags,
  input  logic             useImm,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] regB,
  input  logic [ShW-1:0]   shiftAmt,
  input  logic [ImmW-1:0]  immByte,
  input  logic [RotW-1:0]  immRot,
  output logic [DataW-1:0] result,
  output logic             resultWe,
  output logic             nextN,
  output logic             nextZ,
  output logic             nextC,
  output logic             nextV,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  aluStrobe_t strb;

  alu_ctrl u_ctrl (
    .opValid  (opValid),
    .opcode   (opcode),
    .setFlags (setFlags),
    .strb     (strb)
  );

  alu_datapath #(
    .DataW (DataW),
    .ImmW  (ImmW),
    .RotW  (RotW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .regB     (regB),
    .shiftAmt (shiftAmt),
    .useImm   (useImm),
    .immByte  (immByte),
    .immRot   (immRot),
    .result   (result),
    .resultWe (resultWe),
    .nextN    (nextN),
    .nextZ    (nextZ),
    .nextC    (nextC),
    .nextV    (nextV),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV)
  );

  a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opcode[3:2] == 2'b10) |-> !resultWe);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable({flagN, flagZ, flagC, flagV}));

  a_r13_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !resultWe);

endmodule

// File: tb/dp_alu_tb.sv
`timescale 1ns/100ps
module dp_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        setFlags = 1'b0;
  logic        useImm = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] regB = '0;
  logic [4:0]  shiftAmt = '0;
  logic [7:0]  immByte = '0;
  logic [3:0]  immRot = '0;
  logic [31:0] result;
  logic        resultWe, nextN, nextZ, nextC, nextV;
  logic        flagN, flagZ, flagC, flagV;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .setFlags(setFlags), .useImm(useImm), .opA(opA), .regB(regB),
    .shiftAmt(shiftAmt), .immByte(immByte), .immRot(immRot),
    .result(result), .resultWe(resultWe), .nextN(nextN), .nextZ(nextZ),
    .nextC(nextC), .nextV(nextV), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic        imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  ib;
    logic [3:0]  rot;
    logic [4:0]  sh;
    logic [1:0]  pre;  // 0: C0 V0, 1: C1 V0, 2: C1 V1
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{4'h4, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h4, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000001, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h2, 1'b1, 1'b0, 32'h00000005, 32'h00000007, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h2, 1'b1, 1'b0, 32'h80000000, 32'h00000001, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h3, 1'b1, 1'b0, 32'h00000003, 32'h0000000A, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h5, 1'b1, 1'b0, 32'h00000001, 32'h00000002, 8'h00, 4'h0, 5'd0,  2'd1},
    '{4'h6, 1'b1, 1'b0, 32'h0000000A, 32'h00000003, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h6, 1'b1, 1'b0, 32'h0000000A, 32'h00000003, 8'h00, 4'h0, 5'd0,  2'd1},
    '{4'h7, 1'b1, 1'b0, 32'h00000003, 32'h0000000A, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h0, 1'b1, 1'b1, 32'hF0F0F0F0, 32'h00000000, 8'hFF, 4'h4, 5'd0,  2'd0},
    '{4'h1, 1'b1, 1'b0, 32'h00000010, 32'h10000001, 8'h00, 4'h0, 5'd4,  2'd2},
    '{4'hC, 1'b0, 1'b0, 32'h00F00000, 32'h0000000F, 8'h00, 4'h0, 5'd0,  2'd2},
    '{4'hD, 1'b1, 1'b1, 32'h12345678, 32'h00000000, 8'h3F, 4'h0, 5'd0,  2'd1},
    '{4'hF, 1'b1, 1'b0, 32'hDEADBEEF, 32'h00000000, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'hE, 1'b1, 1'b0, 32'h000000FF, 32'h0000000F, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h8, 1'b0, 1'b0, 32'h00000001, 32'h00000002, 8'h00, 4'h0, 5'd0,  2'd2},
    '{4'h9, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'hA, 1'b0, 1'b0, 32'h00000003, 32'h00000005, 8'h00, 4'h0, 5'd0,  2'd1},
    '{4'hB, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 4'h0, 5'd0,  2'd0},
    '{4'h2, 1'b1, 1'b1, 32'h00000000, 32'h00000000, 8'h01, 4'h1, 5'd0,  2'd0},
    '{4'hD, 1'b1, 1'b0, 32'h00000000, 32'h00000003, 8'h00, 4'h0, 5'd31, 2'd0}
  };

  // Operand 2 and its shifter carry, per R10 and R11
  function automatic logic [32:0] op2Model(logic imm, logic [31:0] b, logic [7:0] ib,
                                           logic [3:0] rot, logic [4:0] sh, logic cin);
    logic [31:0] v;
    logic        c;
    int          d;
    if (imm) begin
      d = 2 * int'(rot);
      v = 32'(ib);
      for (int i = 0; i < d; i++) v = {v[0], v[31:1]};
      c = (rot == 0) ? cin : v[31];
    end else begin
      v = b << sh;
      c = (sh == 0) ? cin : b[32 - int'(sh)];
    end
    return {c, v};
  endfunction

  // Returns {n, z, c, v, result} per R1..R9
  function automatic logic [35:0] aluModel(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                           logic shc, logic cin, logic vin);
    logic [31:0] r;
    logic        c, v;
    longint      sa, sb, s;
    logic        arith;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s = 0; c = shc; v = vin; arith = 1'b1;
    case (op)
      4'h4, 4'hB: begin r = a + b; c = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF; s = sa + sb; end
      4'h5: begin r = a + b + 32'(cin);
                  c = ({1'b0, a} + {1'b0, b} + 33'(cin)) > 33'hFFFFFFFF;
                  s = sa + sb + longint'(cin); end
      4'h2, 4'hA: begin r = a - b; c = (a >= b); s = sa - sb; end
      4'h3: begin r = b - a; c = (b >= a); s = sb - sa; end
      4'h6: begin r = a - b - 32'(!cin);
                  c = ({1'b0, a} >= ({1'b0, b} + 33'(!cin)));
                  s = sa - sb - longint'(!cin); end
      4'h7: begin r = b - a - 32'(!cin);
                  c = ({1'b0, b} >= ({1'b0, a} + 33'(!cin)));
                  s = sb - sa - longint'(!cin); end
      4'h0, 4'h8: begin r = a & b; arith = 1'b0; end
      4'h1, 4'h9: begin r = a ^ b; arith = 1'b0; end
      4'hC: begin r = a | b; arith = 1'b0; end
      4'hE: begin r = a & ~b; arith = 1'b0; end
      4'hD: begin r = b; arith = 1'b0; end
      default: begin r = ~b; arith = 1'b0; end
    endcase
    if (arith) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    return {r[31], (r == 32'h0), c, v, r};
  endfunction

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'h2, 4'h3, 4'h4: return "R1";
      4'h5, 4'h6, 4'h7: return "R2";
      4'hD, 4'hF:       return "R4";
      4'h8, 4'h9, 4'hA, 4'hB: return "R5";
      default:          return "R3";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [3:0] op, logic s, logic imm, logic [31:0] a,
                       logic [31:0] b, logic [7:0] ib, logic [3:0] rot, logic [4:0] sh);
    @(negedge clk);
    opValid = v; opcode = op; setFlags = s; useImm = imm; opA = a;
    regB = b; immByte = ib; immRot = rot; shiftAmt = sh;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; setFlags = 1'b0;
  endtask

  // Preload flags with a compare, then return to idle
  task automatic preset(logic [1:0] p);
    case (p)
      2'd0: drive(1'b1, 4'hB, 1'b0, 1'b0, 32'h0, 32'h0, 8'h0, 4'h0, 5'd0);
      2'd1: drive(1'b1, 4'hA, 1'b0, 1'b0, 32'h0, 32'h0, 8'h0, 4'h0, 5'd0);
      default: drive(1'b1, 4'hA, 1'b0, 1'b0, 32'h80000000, 32'h1, 8'h0, 4'h0, 5'd0);
    endcase
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] presetFlags(logic [1:0] p);
    case (p)
      2'd0: return 4'b0100;
      2'd1: return 4'b0110;
      default: return 4'b0011;
    endcase
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0]  pf, expF;
    logic [32:0] o2;
    logic [35:0] m;
    logic        expWe, flagUpd;
    logic [31:0] keep;

    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12", "flags in reset", {28'h0, flagN, flagZ, flagC, flagV}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R12", "flags after reset", {28'h0, flagN, flagZ, flagC, flagV}, 32'h0);
    check("R13", "idle write strobe", {31'h0, resultWe}, 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      preset(VECS[i].pre);
      pf = presetFlags(VECS[i].pre);
      o2 = op2Model(VECS[i].imm, VECS[i].b, VECS[i].ib, VECS[i].rot, VECS[i].sh, pf[1]);
      m  = aluModel(VECS[i].op, VECS[i].a, o2[31:0], o2[32], pf[1], pf[0]);
      expWe   = (VECS[i].op[3:2] != 2'b10);
      flagUpd = VECS[i].s || !expWe;
      drive(1'b1, VECS[i].op, VECS[i].s, VECS[i].imm, VECS[i].a, VECS[i].b,
            VECS[i].ib, VECS[i].rot, VECS[i].sh);
      check(expWe ? "R6" : "R5", "write strobe", {31'h0, resultWe}, {31'h0, expWe});
      if (expWe) check(reqOf(VECS[i].op), $sformatf("result vec %0d", i), result, m[31:0]);
      check("R8", $sformatf("next flags vec %0d", i),
            {28'h0, nextN, nextZ, nextC, nextV}, {28'h0, m[35:32]});
      @(posedge clk); #1;
      expF = flagUpd ? m[35:32] : pf;
      check(flagUpd ? "R7" : "R6", $sformatf("stored flags vec %0d", i),
            {28'h0, flagN, flagZ, flagC, flagV}, {28'h0, expF});
      idle();
    end

    // R9: logical op keeps V=1 and takes shifter carry (shift 4 of bit 28)
    preset(2'd2);
    drive(1'b1, 4'h1, 1'b1, 1'b0, 32'h0, 32'h10000000, 8'h0, 4'h0, 5'd4);
    @(posedge clk); #1;
    check("R9", "logic keeps V, C from shifter", {28'h0, flagN, flagZ, flagC, flagV}, 32'h7);
    idle();

    // R10: rotate 15 (30 bits) of 0x01 gives 0x00000004, carry bit31 = 0
    preset(2'd1);
    drive(1'b1, 4'hD, 1'b1, 1'b1, 32'h0, 32'h0, 8'h01, 4'hF, 5'd0);
    check("R10", "immediate rotate", result, 32'h00000004);
    check("R10", "immediate carry", {31'h0, nextC}, 32'h0);
    idle();

    // R11: shift 1 of 0x80000001 gives 2, carry 1
    preset(2'd0);
    drive(1'b1, 4'hD, 1'b1, 1'b0, 32'h0, 32'h80000001, 8'h0, 4'h0, 5'd1);
    check("R11", "register shift", result, 32'h00000002);
    check("R11", "shift carry", {31'h0, nextC}, 32'h1);
    idle();

    // R4: move result unaffected by A
    drive(1'b1, 4'hF, 1'b0, 1'b0, 32'hAAAAAAAA, 32'h0000FFFF, 8'h0, 4'h0, 5'd0);
    keep = result;
    drive(1'b1, 4'hF, 1'b0, 1'b0, 32'h55555555, 32'h0000FFFF, 8'h0, 4'h0, 5'd0);
    check("R4", "negated move ignores A", result, keep);
    check("R4", "negated move value", result, 32'hFFFF0000);
    idle();

    // R2: 64-bit add 0x00000001_FFFFFFFF + 0x00000002_00000001
    preset(2'd0);
    drive(1'b1, 4'h4, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h0, 4'h0, 5'd0);
    check("R2", "low word", result, 32'h0);
    @(posedge clk); #1;
    drive(1'b1, 4'h5, 1'b0, 1'b0, 32'h00000001, 32'h00000002, 8'h0, 4'h0, 5'd0);
    check("R2", "high word with carry", result, 32'h00000004);
    idle();

    // R13: compare code with opValid low changes nothing
    preset(2'd2);
    drive(1'b0, 4'hA, 1'b1, 1'b0, 32'h5, 32'h5, 8'h0, 4'h0, 5'd0);
    check("R13", "idle write strobe", {31'h0, resultWe}, 32'h0);
    @(posedge clk); #1;
    check("R13", "idle flags held", {28'h0, flagN, flagZ, flagC, flagV}, 32'h3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule